// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit parallel ports, A, B and C, behind a small register window. The window is addressed through an 8-bit data bus and a two-bit register address. Chip select, read and write are all active low. Port A and the upper half of port C form one group. Port B and the lower half of port C form the other. One control register sets each group's operating mode and each port's direction. A second command format on the same address sets or clears one port C bit at a time.

In the basic mode, each port is a plain latched output or a live input. In the strobed modes, individual port C lines become handshake lines:
- An external strobe captures input data and raises a buffer-full flag. A processor read lowers that flag again.
- A processor write lowers an output-full line. An external acknowledge raises it again.

Group A also has a bidirectional mode. In that mode port A drives the pins only while the acknowledge line is held low. Pads are modelled as separate input, output and output-enable signals. Reset is synchronous and active high. A bus access takes effect once, at the first clock edge where its strobe is seen low.

Top module: `ppi_top`

## Requirements
- R1: After reset, every output enable (`dout_oe`, `pa_oe`, `pb_oe`, `pc_oe`) is 0, all ports act as inputs in the basic mode, and a read of address 3 returns 0x00.
- R2: An access counts only while `cs_n` is low. `dout_oe` is 1 for exactly the cycle after each clock edge where `cs_n` and `rd_n` are both low. A write with `cs_n` high changes nothing.
- R3: A write to address 3 with bit 7 set is a mode command:
  - bits 6:5 give the group A mode, where 00 is basic, 01 is strobed and 1x is bidirectional;
  - bit 4 sets the port A direction and bit 3 the upper C direction;
  - bit 2 gives the group B mode (0 basic, 1 strobed);
  - bit 1 sets the port B direction and bit 0 the lower C direction;
  - in every direction bit, 1 means input.
- R4: In the basic mode, addresses 0, 1 and 2 select ports A, B and C. An output port drives its write latch, and a read of it returns that latch. A read of an input port returns the live pins.
- R5: A mode command clears the port A, B and C output latches to 0 and clears all handshake state.
- R6: A write to address 3 with bit 7 clear sets port C bit number din[3:1] to din[0] and leaves the other seven latch bits unchanged.
- R7: A read of port C returns the latch value on lines driven as outputs and the live pin on all other lines. The two halves of port C take their directions independently.
- R8: Strobed input captures port data on the falling edge of its strobe: line 4 for port A, line 2 for port B. It then raises the buffer-full line (C line 5 for A, line 1 for B). Later pin changes do not alter the captured value. A processor read of the port returns the captured value and lowers the flag.
- R9: In strobed output, a processor write to the port drives its output-full line low (C line 7 for A, line 1 for B). The acknowledge input (C line 6 for A, line 2 for B) being low drives the output-full line high again.
- R10: In bidirectional mode, `pa_oe` equals the inverse of C line 6. Input capture (strobe on line 4, flag on line 5) and output handshake (flag on line 7) both work on port A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_oe | output | 1 | Read data bus driver enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C per-line drive enables |

## Verification
The hardest situation to reach is a handshake flag whose state depends on the order of external line events and processor accesses. An example is a captured byte that must survive later pin changes until a read, then drop its flag at that read. The bench first selects a strobed or bidirectional mode. It then toggles single port C lines for exactly one cycle while holding distinct data patterns on the port pins. After that it changes the pins again and reads the port. For the bidirectional case, the acknowledge line is held low and released across separate cycles, so the port drive enable is seen to follow it.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int BUS_W = 8;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    SEL_PA   = 2'd0,
    SEL_PB   = 2'd1,
    SEL_PC   = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic cfg_t decode_cfg(input logic [BUS_W-1:0] w);
    cfg_t c;
    c.a_mode = w[6] ? 2'd2 : {1'b0, w[5]};
    c.a_in   = w[4];
    c.cu_in  = w[3];
    c.b_mode = w[2];
    c.b_in   = w[1];
    c.cl_in  = w[0];
    return c;
  endfunction
endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_act,
  output logic rd_hit,
  output logic wr_hit
);
  logic rd_q, wr_q;
  logic wr_act;

  assign rd_act = !cs_n && !rd_n;
  assign wr_act = !cs_n && !wr_n;
  assign rd_hit = rd_act && !rd_q;
  assign wr_hit = wr_act && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assert_single_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !wr_hit);
endmodule

// File: rtl/ppi_hs_chan.sv
module ppi_hs_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         in_en,
  input  logic         out_en,
  input  logic         stb_n,
  input  logic         ack_n,
  input  logic [W-1:0] pins,
  input  logic         rd_hit,
  input  logic         wr_hit,
  output logic [W-1:0] held,
  output logic         ibf,
  output logic         obf_n
);
  logic stb_q;
  logic stb_fall;

  assign stb_fall = in_en && stb_q && !stb_n;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stb_q <= 1'b1;
      held  <= '0;
      ibf   <= 1'b0;
      obf_n <= 1'b1;
    end else begin
      stb_q <= stb_n;
      if (stb_fall) begin
        held <= pins;
        ibf  <= 1'b1;
      end else if (rd_hit) begin
        ibf <= 1'b0;
      end
      if (out_en && wr_hit)
        obf_n <= 1'b0;
      else if (out_en && !ack_n)
        obf_n <= 1'b1;
    end
  end

  assert_ibf_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(in_en && !stb_n));
  assert_obf_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(obf_n) |-> $past(out_en && wr_hit));
  assert_clear_flags_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!ibf && obf_n));
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe,
  input  logic [BUS_W-1:0] pa_in,
  output logic [BUS_W-1:0] pa_out,
  output logic             pa_oe,
  input  logic [BUS_W-1:0] pb_in,
  output logic [BUS_W-1:0] pb_out,
  output logic             pb_oe,
  input  logic [BUS_W-1:0] pc_in,
  output logic [BUS_W-1:0] pc_out,
  output logic [BUS_W-1:0] pc_oe
);
  localparam int HALF = BUS_W / 2;

  logic rd_act, rd_hit, wr_hit;
  cfg_t cfg;
  logic [BUS_W-1:0] pa_lat, pb_lat, pc_lat;
  logic mode_clr;
  logic a_in_en, a_out_en, b_in_en, b_out_en;
  logic [BUS_W-1:0] held_a, held_b;
  logic ibf_a, ibf_b, obf_n_a, obf_n_b;
  logic [BUS_W-1:0] rd_mux;
  sel_e sel;

  assign sel = sel_e'(addr);

  ppi_bus_if u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_act(rd_act), .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  assign mode_clr = wr_hit && sel == SEL_CTRL && din[BUS_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= CFG_RESET;
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else if (wr_hit) begin
      unique case (sel)
        SEL_PA: pa_lat <= din;
        SEL_PB: pb_lat <= din;
        SEL_PC: pc_lat <= din;
        SEL_CTRL: begin
          if (din[BUS_W-1]) begin
            cfg    <= decode_cfg(din);
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
          end else begin
            pc_lat[din[SEL_W:1]] <= din[0];
          end
        end
      endcase
    end
  end

  assign a_in_en  = (cfg.a_mode == 2'd1 && cfg.a_in)  || cfg.a_mode == 2'd2;
  assign a_out_en = (cfg.a_mode == 2'd1 && !cfg.a_in) || cfg.a_mode == 2'd2;
  assign b_in_en  = cfg.b_mode && cfg.b_in;
  assign b_out_en = cfg.b_mode && !cfg.b_in;

  ppi_hs_chan #(.W(BUS_W)) u_chan_a (
    .clk(clk), .rst(rst), .clr(mode_clr),
    .in_en(a_in_en), .out_en(a_out_en),
    .stb_n(pc_in[4]), .ack_n(pc_in[6]), .pins(pa_in),
    .rd_hit(rd_hit && sel == SEL_PA), .wr_hit(wr_hit && sel == SEL_PA),
    .held(held_a), .ibf(ibf_a), .obf_n(obf_n_a)
  );

  ppi_hs_chan #(.W(BUS_W)) u_chan_b (
    .clk(clk), .rst(rst), .clr(mode_clr),
    .in_en(b_in_en), .out_en(b_out_en),
    .stb_n(pc_in[2]), .ack_n(pc_in[2]), .pins(pb_in),
    .rd_hit(rd_hit && sel == SEL_PB), .wr_hit(wr_hit && sel == SEL_PB),
    .held(held_b), .ibf(ibf_b), .obf_n(obf_n_b)
  );

  assign pa_out = pa_lat;
  assign pa_oe  = (cfg.a_mode == 2'd2) ? !pc_in[6] : !cfg.a_in;
  assign pb_out = pb_lat;
  assign pb_oe  = !cfg.b_in;

  always_comb begin
    pc_out = pc_lat;
    pc_oe  = {{HALF{!cfg.cu_in}}, {HALF{!cfg.cl_in}}};
    if (a_in_en) begin
      pc_oe[4]  = 1'b0;
      pc_oe[5]  = 1'b1;
      pc_out[5] = ibf_a;
    end
    if (a_out_en) begin
      pc_oe[6]  = 1'b0;
      pc_oe[7]  = 1'b1;
      pc_out[7] = obf_n_a;
    end
    if (b_in_en) begin
      pc_oe[2]  = 1'b0;
      pc_oe[1]  = 1'b1;
      pc_out[1] = ibf_b;
    end
    if (b_out_en) begin
      pc_oe[2]  = 1'b0;
      pc_oe[1]  = 1'b1;
      pc_out[1] = obf_n_b;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PA:   rd_mux = a_in_en ? held_a :
                         ((cfg.a_mode == 2'd0 && cfg.a_in) ? pa_in : pa_lat);
      SEL_PB:   rd_mux = b_in_en ? held_b :
                         ((!cfg.b_mode && cfg.b_in) ? pb_in : pb_lat);
      SEL_PC:   rd_mux = (pc_oe & pc_out) | (~pc_oe & pc_in);
      SEL_CTRL: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_act;
      if (rd_act) dout <= rd_mux;
    end
  end

  assert_oe_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(!cs_n && !rd_n));
  assert_ctrl_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(addr) == 2'd3) |-> dout == '0);
  assert_mode_clears_latch_R5: assert property (@(posedge clk) disable iff (rst)
    mode_clr |=> (pa_out == '0 && pb_out == '0));
  assert_bidir_drive_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg.a_mode == 2'd2 && !pc_in[6]) |-> pa_oe);
endmodule

// File: tb/test_ppi_top.sv
module test_ppi_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic pa_oe, pb_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  ppi_top i_ppi_top (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    addr = a; din = d; cs_n = !sel; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_pc(input int b);
    @(negedge clk);
    pc_in[b] = 1'b0;
    @(negedge clk);
    pc_in[b] = 1'b1;
    @(negedge clk);
  endtask

  // Scoreboard monitor: compares every driven read against the queued value.
  always @(negedge clk) begin
    if (!rst && dout_oe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual unexpected read %h expected none", dout);
      end else begin
        check(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", {4'b0, dout_oe, pa_oe, pb_oe, 1'b0}, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    pa_in = 8'h21;
    bus_read(2'd0, 8'h21, "R1 reset port A input");
    bus_read(2'd3, 8'h00, "R1 ctrl read");

    // R3/R4 all outputs in basic mode
    bus_write(2'd3, 8'h80);
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hC3);
    check("R4 pa_out", pa_out, 8'h5A);
    check("R4 pb_out", pb_out, 8'hC3);
    check("R3 oe", {6'b0, pa_oe, pb_oe}, 8'h03);
    bus_read(2'd0, 8'h5A, "R4 read output latch");
    check("R2 oe low after read", {7'b0, dout_oe}, 8'h00);

    // R2 deselected write ignored
    bus_write(2'd0, 8'hFF, 1'b0);
    check("R2 deselected write", pa_out, 8'h5A);

    // R5 mode command clears latches
    bus_write(2'd3, 8'h80);
    check("R5 pa cleared", pa_out, 8'h00);
    check("R5 pb cleared", pb_out, 8'h00);

    // R3/R4 mixed directions: A in, CU in, B out, CL in
    bus_write(2'd3, 8'h99);
    pa_in = 8'h3C; pc_in = 8'hA5;
    check("R3 dirs", {6'b0, pa_oe, pb_oe}, 8'h01);
    check("R3 pc_oe", pc_oe, 8'h00);
    bus_read(2'd0, 8'h3C, "R4 live input");
    bus_read(2'd2, 8'hA5, "R7 all-input port C");

    // R6/R7 bit set/reset, upper C in, lower C out
    pc_in = 8'hFF;
    bus_write(2'd3, 8'h88);
    check("R7 pc_oe halves", pc_oe, 8'h0F);
    bus_write(2'd3, 8'h05);
    bus_write(2'd3, 8'h0F);
    check("R6 set bit2", pc_out & 8'h0F, 8'h04);
    pc_in = 8'h3B;
    bus_read(2'd2, 8'h34, "R7 mixed port C read");
    bus_write(2'd3, 8'h04);
    check("R6 clear bit2", pc_out & 8'h0F, 8'h00);
    pc_in = 8'hFF;
    bus_read(2'd2, 8'hF0, "R6 upper latch hidden");

    // R8 strobed input on port A
    bus_write(2'd3, 8'hB0);
    check("R8 pc_oe 5:4", {6'b0, pc_oe[5:4]}, 8'h02);
    check("R8 ibf idle", {7'b0, pc_out[5]}, 8'h00);
    pa_in = 8'h77;
    pulse_pc(4);
    check("R8 ibf set", {7'b0, pc_out[5]}, 8'h01);
    pa_in = 8'h11;
    bus_read(2'd0, 8'h77, "R8 captured data");
    check("R8 ibf cleared by read", {7'b0, pc_out[5]}, 8'h00);

    // R9 strobed output on port B
    bus_write(2'd3, 8'h84);
    check("R9 obf idle", {7'b0, pc_out[1]}, 8'h01);
    bus_write(2'd1, 8'h9E);
    check("R9 obf low", {7'b0, pc_out[1]}, 8'h00);
    check("R9 pb_out", pb_out, 8'h9E);
    pulse_pc(2);
    check("R9 ack releases obf", {7'b0, pc_out[1]}, 8'h01);

    // R8 strobed input on port B
    bus_write(2'd3, 8'h86);
    pb_in = 8'h6D;
    pulse_pc(2);
    check("R8 B ibf set", {7'b0, pc_out[1]}, 8'h01);
    pb_in = 8'h00;
    bus_read(2'd1, 8'h6D, "R8 B captured data");
    check("R8 B ibf cleared", {7'b0, pc_out[1]}, 8'h00);

    // R10 bidirectional port A
    bus_write(2'd3, 8'hC0);
    check("R10 pa_oe idle", {7'b0, pa_oe}, 8'h00);
    bus_write(2'd0, 8'h42);
    check("R10 obf low", {7'b0, pc_out[7]}, 8'h00);
    @(negedge clk);
    pc_in[6] = 1'b0;
    #1;
    check("R10 pa_oe with ack", {7'b0, pa_oe}, 8'h01);
    check("R10 pa_out", pa_out, 8'h42);
    @(negedge clk);
    pc_in[6] = 1'b1;
    #1;
    check("R10 pa_oe released", {7'b0, pa_oe}, 8'h00);
    @(negedge clk);
    check("R10 obf released", {7'b0, pc_out[7]}, 8'h01);
    pa_in = 8'hE1;
    pulse_pc(4);
    check("R10 ibf set", {7'b0, pc_out[5]}, 8'h01);
    pa_in = 8'h0F;
    bus_read(2'd0, 8'hE1, "R10 captured data");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: actual %0d reads missing expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule